// File: doc/BRIEF.md
# Checksum-Gated NMEA Sentence Capture

This block listens to the serial output of a satellite positioning receiver and hands complete, verified NMEA sentences to a host processor. It derives a 16x oversampling tick from the system clock, recovers 8N1 bytes with a receive state machine, and frames sentences between the `$` lead-in and the CR/LF terminator. Every byte of the sentence body is written into a private staging buffer while an XOR checksum runs over it.

A staged sentence reaches the host only after the two hex digits after `*` have been matched against the running checksum and the line has been properly terminated. At that point the body is copied into a host-visible dual-port buffer. Address 0 of that buffer holds the body length and addresses 1 to length hold the body bytes. An active-low busy line stays low for the whole copy and acts as the host's interrupt. The host reads through its own address/data port at any time, and a new sentence typically arrives once per second.

Top module: `nmea_capture`

## Requirements
- R1: After reset busy_n is high and the length word at host address 0 reads 0.
- R2: Bytes are received as 8N1, least significant bit first. Timing uses a tick every CLK_HZ/(BAUD*OVS) clocks with OVS ticks per bit. A start bit is accepted only if the line is still low at its middle, so a low pulse shorter than half a bit produces no byte.
- R3: A sentence starts at `$` (0x24), and bytes before it are ignored. The body is every byte after `$` and before `*` (0x2A). The body must be followed by exactly two hex digits and then CR (0x0D) and LF (0x0A).
- R4: The checksum is the XOR of all body bytes. The first hex digit is the high nibble, and the digits 0-9, A-F and a-f are accepted. A mismatch discards the sentence.
- R5: A `$` received anywhere inside a sentence drops what was staged and starts a new sentence.
- R6: A body of up to STAGE_DEPTH bytes is accepted. A body byte beyond STAGE_DEPTH discards the sentence.
- R7: A byte whose stop bit is sampled low is a framing error and aborts the sentence. A non-hex checksum digit, or a missing CR or LF, also aborts it.
- R8: When the LF of a valid sentence arrives, busy_n falls one clock after the byte is recovered and stays low for length+1 clocks. During that time the body is written to host addresses 1..length and the length to address 0. A discarded sentence causes no busy pulse and changes no host-visible byte.
- R9: host_rdata returns the buffer byte at host_addr one clock later, and addresses above STAGE_DEPTH read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| host_addr | input | $clog2(STAGE_DEPTH+1) | Host read address (0 = length) |
| host_rdata | output | 8 | Host read data, registered |
| busy_n | output | 1 | Low while a sentence is committed; host interrupt |

## Verification
The bench drives a small configuration (8-byte staging buffer, two clocks per oversample tick) and targets the discard paths. These are a wrong checksum, a `$` restart, a body one byte too long, a bad stop bit and a missing CR. A design that leaks staged data on any of these would change the host-visible length or bytes, or pulse busy_n. A design that ignored framing errors would commit the sentence that follows the bad byte. The bench also covers the edge cases of an empty body, a body exactly filling the buffer and lowercase checksum digits, where a wrong design would reject good sentences or report a wrong length. It checks that a short glitch creates no phantom byte, and that the busy pulse width tracks the length exactly.

// File: rtl/nmea_pkg.sv
package nmea_pkg;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    typedef enum logic [2:0] {
        FR_HUNT, FR_BODY, FR_SUM_HI, FR_SUM_LO, FR_WAIT_CR, FR_WAIT_LF
    } frame_state_e;

    typedef enum logic [1:0] {CM_IDLE, CM_COPY, CM_LEN} commit_state_e;

    typedef struct packed {
        logic       valid;
        logic       ferr;
        logic [7:0] data;
    } rx_byte_t;

    typedef struct packed {
        logic       ok;
        logic [3:0] nib;
    } hex_digit_t;

    function automatic hex_digit_t hex_decode(input logic [7:0] c);
        hex_digit_t h;
        h.ok  = 1'b1;
        h.nib = 4'h0;
        if (c >= 8'h30 && c <= 8'h39)      h.nib = 4'(c - 8'h30);
        else if (c >= 8'h41 && c <= 8'h46) h.nib = 4'(c - 8'h37);
        else if (c >= 8'h61 && c <= 8'h66) h.nib = 4'(c - 8'h57);
        else                               h.ok  = 1'b0;
        return h;
    endfunction

endpackage

// File: rtl/nmea_baud_tick.sv
module nmea_baud_tick #(
    parameter int DIV = 104
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    generate
        if (DIV <= 1) begin : g_pass
            always_ff @(posedge clk) begin
                if (rst) tick <= 1'b0;
                else     tick <= 1'b1;
            end
            assign cnt = '0;
        end else begin : g_div
            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else begin
                    tick <= (cnt == CW'(DIV - 1));
                    cnt  <= (cnt == CW'(DIV - 1)) ? '0 : cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/nmea_uart_rx.sv
module nmea_uart_rx
    import nmea_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    output rx_byte_t rx_out
);
    localparam int SW   = $clog2(OVS);
    localparam int MID  = OVS / 2 - 1;
    localparam int LAST = OVS - 1;

    rx_state_e   st;
    logic [SW-1:0] sc;
    logic [2:0]  bi;
    logic [7:0]  sh;
    logic        sync0, rx_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync0 <= 1'b1;
            rx_s  <= 1'b1;
        end else begin
            sync0 <= rxd;
            rx_s  <= sync0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RX_IDLE;
            sc     <= '0;
            bi     <= '0;
            sh     <= '0;
            rx_out <= '0;
        end else begin
            rx_out.valid <= 1'b0;
            rx_out.ferr  <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            st <= RX_START;
                            sc <= '0;
                        end
                    end
                    RX_START: begin
                        if (sc == SW'(MID)) begin
                            sc <= '0;
                            bi <= '0;
                            st <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            sc <= sc + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sc == SW'(LAST)) begin
                            sc <= '0;
                            sh <= {rx_s, sh[7:1]};
                            if (bi == 3'd7) st <= RX_STOP;
                            else            bi <= bi + 1'b1;
                        end else begin
                            sc <= sc + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (sc == SW'(LAST)) begin
                            st           <= RX_IDLE;
                            sc           <= '0;
                            rx_out.data  <= sh;
                            rx_out.valid <= rx_s;
                            rx_out.ferr  <= !rx_s;
                        end else begin
                            sc <= sc + 1'b1;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/nmea_framer.sv
module nmea_framer
    import nmea_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  rx_byte_t      rx_in,
    input  logic [AW-1:0] rd_idx,
    output logic [7:0]    rd_data,
    output logic          commit_go,
    output logic [LW-1:0] commit_len
);
    frame_state_e st;
    logic [LW-1:0] cnt;
    logic [7:0]    xsum;
    logic [3:0]    hi_nib;
    logic [7:0]    stage_mem [DEPTH];
    hex_digit_t    dig;

    assign dig        = hex_decode(rx_in.data);
    assign rd_data    = stage_mem[rd_idx];
    assign commit_len = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= FR_HUNT;
            cnt       <= '0;
            xsum      <= '0;
            hi_nib    <= '0;
            commit_go <= 1'b0;
        end else begin
            commit_go <= 1'b0;
            if (rx_in.ferr) begin
                st <= FR_HUNT;
            end else if (rx_in.valid) begin
                if (rx_in.data == CH_DOLLAR) begin
                    st   <= FR_BODY;
                    cnt  <= '0;
                    xsum <= '0;
                end else begin
                    unique case (st)
                        FR_HUNT: ;
                        FR_BODY: begin
                            if (rx_in.data == CH_STAR) begin
                                st <= FR_SUM_HI;
                            end else if (cnt == LW'(DEPTH)) begin
                                st <= FR_HUNT;
                            end else begin
                                stage_mem[cnt[AW-1:0]] <= rx_in.data;
                                cnt  <= cnt + 1'b1;
                                xsum <= xsum ^ rx_in.data;
                            end
                        end
                        FR_SUM_HI: begin
                            hi_nib <= dig.nib;
                            st     <= dig.ok ? FR_SUM_LO : FR_HUNT;
                        end
                        FR_SUM_LO: begin
                            st <= (dig.ok && {hi_nib, dig.nib} == xsum) ? FR_WAIT_CR : FR_HUNT;
                        end
                        FR_WAIT_CR: begin
                            st <= (rx_in.data == CH_CR) ? FR_WAIT_LF : FR_HUNT;
                        end
                        FR_WAIT_LF: begin
                            st        <= FR_HUNT;
                            commit_go <= (rx_in.data == CH_LF);
                        end
                        default: st <= FR_HUNT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/nmea_commit.sv
module nmea_commit
    import nmea_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int HAW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [LW-1:0]  len,
    input  logic [7:0]     stage_data,
    output logic [AW-1:0]  stage_idx,
    output logic           busy_n,
    input  logic [HAW-1:0] host_addr,
    output logic [7:0]     host_rdata
);
    commit_state_e st;
    logic [LW-1:0] idx;
    logic [LW-1:0] lat_len;
    logic [LW-1:0] len_q;
    logic [7:0]    dp_mem [DEPTH];

    assign stage_idx = idx[AW-1:0];
    assign busy_n    = (st == CM_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= CM_IDLE;
            idx     <= '0;
            lat_len <= '0;
            len_q   <= '0;
        end else begin
            unique case (st)
                CM_IDLE: begin
                    if (go) begin
                        lat_len <= len;
                        idx     <= '0;
                        st      <= (len == '0) ? CM_LEN : CM_COPY;
                    end
                end
                CM_COPY: begin
                    dp_mem[idx[AW-1:0]] <= stage_data;
                    idx <= idx + 1'b1;
                    if (idx == lat_len - 1'b1) st <= CM_LEN;
                end
                CM_LEN: begin
                    len_q <= lat_len;
                    st    <= CM_IDLE;
                end
                default: st <= CM_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                host_rdata <= '0;
        else if (host_addr == '0)               host_rdata <= 8'(len_q);
        else if (host_addr <= HAW'(DEPTH))      host_rdata <= dp_mem[AW'(host_addr - 1'b1)];
        else                                    host_rdata <= '0;
    end
endmodule

// File: rtl/nmea_capture.sv
module nmea_capture
    import nmea_pkg::*;
#(
    parameter int CLK_HZ      = 8_000_000,
    parameter int BAUD        = 4800,
    parameter int OVS         = 16,
    parameter int STAGE_DEPTH = 128,
    localparam int HAW        = $clog2(STAGE_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rxd,
    input  logic [HAW-1:0] host_addr,
    output logic [7:0]     host_rdata,
    output logic           busy_n
);
    localparam int DIV = CLK_HZ / (BAUD * OVS);
    localparam int AW  = $clog2(STAGE_DEPTH);
    localparam int LW  = $clog2(STAGE_DEPTH + 1);

    logic          tick;
    rx_byte_t      rxb;
    logic          rx_valid, rx_ferr;
    logic [AW-1:0] stage_idx;
    logic [7:0]    stage_data;
    logic          commit_go;
    logic [LW-1:0] commit_len;

    assign rx_valid = rxb.valid;
    assign rx_ferr  = rxb.ferr;

    nmea_baud_tick #(.DIV(DIV)) u_tick (
        .clk (clk), .rst (rst), .tick (tick)
    );

    nmea_uart_rx #(.OVS(OVS)) u_rx (
        .clk (clk), .rst (rst), .tick (tick), .rxd (rxd), .rx_out (rxb)
    );

    nmea_framer #(.DEPTH(STAGE_DEPTH), .AW(AW), .LW(LW)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .rx_in      (rxb),
        .rd_idx     (stage_idx),
        .rd_data    (stage_data),
        .commit_go  (commit_go),
        .commit_len (commit_len)
    );

    nmea_commit #(.DEPTH(STAGE_DEPTH), .AW(AW), .LW(LW), .HAW(HAW)) u_commit (
        .clk        (clk),
        .rst        (rst),
        .go         (commit_go),
        .len        (commit_len),
        .stage_data (stage_data),
        .stage_idx  (stage_idx),
        .busy_n     (busy_n),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );
endmodule

// File: rtl/nmea_capture_chk.sv
module nmea_capture_chk (
    input logic clk,
    input logic rst,
    input logic busy_n,
    input logic byte_valid,
    input logic frame_err,
    input logic commit_go
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> busy_n);

    a_r2_valid_or_ferr: assert property (@(posedge clk) disable iff (rst)
        !(byte_valid && frame_err));

    a_r2_single_cycle_byte: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    a_r8_commit_follows_byte: assert property (@(posedge clk) disable iff (rst)
        commit_go |-> $past(byte_valid));

    a_r8_busy_after_commit: assert property (@(posedge clk) disable iff (rst)
        commit_go |=> !busy_n);

    a_r8_no_commit_while_busy: assert property (@(posedge clk) disable iff (rst)
        !busy_n |-> !commit_go);
endmodule

bind nmea_capture nmea_capture_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy_n     (busy_n),
    .byte_valid (rx_valid),
    .frame_err  (rx_ferr),
    .commit_go  (commit_go)
);

// File: tb/nmea_capture_tb.sv
module nmea_capture_tb;
    localparam int DEPTH = 8;
    localparam int HAW   = $clog2(DEPTH + 1);
    localparam int BITC  = 32; // 2 clocks per tick * 16 ticks

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rxd = 1'b1;
    logic [HAW-1:0] host_addr = '0;
    logic [7:0]     host_rdata;
    logic           busy_n;

    int checks = 0, failures = 0;
    int pulses = 0, low_cycles = 0;
    logic busy_prev = 1'b1;
    bit done = 0;
    string last_body = "";

    always #4 clk = ~clk;

    nmea_capture #(.CLK_HZ(153600), .BAUD(4800), .OVS(16), .STAGE_DEPTH(DEPTH)) u_dut (
        .clk (clk), .rst (rst), .rxd (rxd),
        .host_addr (host_addr), .host_rdata (host_rdata), .busy_n (busy_n)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (!busy_n) low_cycles++;
            if (busy_prev && !busy_n) pulses++;
        end
        busy_prev = busy_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop = 1);
        @(negedge clk) rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = good_stop;
        repeat (BITC) @(negedge clk);
        rxd = 1'b1;
        repeat (good_stop ? BITC : 12 * BITC) @(negedge clk);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    function automatic logic [7:0] xor_of(input string s);
        logic [7:0] x = 8'h00;
        for (int i = 0; i < s.len(); i++) x ^= s[i];
        return x;
    endfunction

    function automatic logic [7:0] hexc(input logic [3:0] n, input bit lower);
        if (n < 10) return 8'h30 + 8'(n);
        return (lower ? 8'h61 : 8'h41) + 8'(n) - 8'd10;
    endfunction

    task automatic send_tail(input logic [7:0] ck, input bit lower);
        send_byte(8'h2A);
        send_byte(hexc(ck[7:4], lower));
        send_byte(hexc(ck[3:0], lower));
        send_byte(8'h0D);
        send_byte(8'h0A);
    endtask

    task automatic send_sentence(input string body, input logic [7:0] ck, input bit lower = 0);
        send_byte(8'h24);
        send_str(body);
        send_tail(ck, lower);
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk) host_addr = HAW'(a);
        @(negedge clk) v = host_rdata;
    endtask

    task automatic verify_content(input string req, input string body);
        int v;
        rd(0, v);
        chk({req, " length word"}, v, body.len());
        for (int i = 0; i < body.len(); i++) begin
            rd(i + 1, v);
            chk({req, " body byte"}, v, body[i]);
        end
    endtask

    task automatic clear_mon();
        repeat (4) @(negedge clk);
        pulses = 0;
        low_cycles = 0;
    endtask

    task automatic expect_commit(input string req, input string body);
        repeat (40) @(negedge clk);
        chk({req, " busy pulse count"}, pulses, 1);
        chk({req, " busy low cycles (len+1)"}, low_cycles, body.len() + 1);
        verify_content(req, body);
        last_body = body;
    endtask

    task automatic expect_reject(input string req);
        repeat (40) @(negedge clk);
        chk({req, " no busy pulse"}, pulses, 0);
        verify_content({req, " unchanged"}, last_body);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1: reset state
        chk("R1 busy_n after reset", busy_n, 1);
        rd(0, v);
        chk("R1 length word after reset", v, 0);

        // R3 R4 R9: noise before '$', good sentence
        clear_mon();
        send_str("xy");
        send_sentence("GPRMC", xor_of("GPRMC"));
        expect_commit("R3 R8 good sentence", "GPRMC");

        // R9: out-of-range host address
        rd(12, v);
        chk("R9 address above depth reads 0", v, 0);

        // R4: wrong checksum discarded
        clear_mon();
        send_sentence("ABC", xor_of("ABC") ^ 8'h01);
        expect_reject("R4 bad checksum");

        // R4: lowercase hex digits ('J' = 0x4A -> "4a")
        clear_mon();
        send_sentence("J", xor_of("J"), 1);
        expect_commit("R4 lowercase digits", "J");

        // R5: restart inside body and inside checksum
        clear_mon();
        send_str("$GARB");
        send_str("$QQ*4");
        send_sentence("NEW,1", xor_of("NEW,1"));
        expect_commit("R5 restart on dollar", "NEW,1");

        // R6: body one byte over depth
        clear_mon();
        send_sentence("123456789", xor_of("123456789"));
        expect_reject("R6 overflow");

        // R6: body exactly at depth
        clear_mon();
        send_sentence("ABCDEFGH", xor_of("ABCDEFGH"));
        expect_commit("R6 full depth", "ABCDEFGH");

        // R7: bad stop bit mid-sentence; the rest would be valid if the error were ignored
        clear_mon();
        send_str("$XY");
        send_byte(8'h5A, 0);
        send_tail(xor_of("XY"), 0);
        expect_reject("R7 framing error");

        // R7: missing CR
        clear_mon();
        send_byte(8'h24);
        send_str("XY");
        send_byte(8'h2A);
        send_byte(hexc(xor_of("XY") >> 4, 0));
        send_byte(hexc(xor_of("XY") & 8'h0F, 0));
        send_byte(8'h0A);
        expect_reject("R7 missing CR");

        // R2: short glitch produces no byte, then a good sentence
        clear_mon();
        @(negedge clk) rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BITC) @(negedge clk);
        send_sentence("OK", xor_of("OK"));
        expect_commit("R2 glitch rejected", "OK");

        // R8: empty body
        clear_mon();
        send_sentence("", 8'h00);
        expect_commit("R8 empty body", "");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule